// File: doc/BRIEF.md
# Hybrid-Mapped Way Placement Controller

This block keeps the per-way status bits of one 16-way cache set in which two classes of line share the same array. A line of the "leading" class always lives at a fixed way derived from its block address. A line of the "following" class may sit in any way. Each request names a block address, the class the block has now, the class last recorded for it, the way it currently occupies and whether the access writes the line. The controller then updates the valid, dirty, reference and priority bits of the set. The priority bit marks the class: 1 for leading, 0 for following.

When a block turns from leading to following, it only loses its priority. When it turns from following to leading, it either gains priority in place, or it leaves a hot leading occupant of its fixed way alone and only cools that occupant. Failing both, it is moved. The move writes back a dirty occupant of the fixed way, copies the line into the fixed way and frees the way it came from. The data movement and the writeback are carried out elsewhere and are seen here only as request/done handshakes. While a move is in progress the controller accepts no new request.

Top module: `hyb_way_ctrl`

## Requirements
- R1: The fixed way of a block is the XOR of block address bits [3:0] with bits [7:4]. This value appears on `wb_way` and `cp_dst` during a move.
- R2: After reset every way is invalid, clean, unreferenced and low priority. `req_ready` is 1, and `wb_req` and `cp_req` are 0.
- R3: A request whose current class equals its recorded class sets the valid and reference bits of `req_way`. It also sets that way's dirty bit when `req_write` is 1, leaves the priority bit unchanged and completes in one cycle.
- R4: A request going from leading (`req_last_lead`=1) to following (`req_cur_lead`=0) clears the priority bit of `req_way`, keeps the line valid and starts no move.
- R5: A request going from following to leading whose `req_way` equals its fixed way sets that way's priority bit and starts no move.
- R6: A request going from following to leading whose fixed way holds a valid line with priority 1 and reference 1 clears that way's reference bit, keeps its priority and starts no move. The requester's way stays valid.
- R7: In every other following-to-leading case where the fixed way is valid and dirty, `wb_req` rises first and is held with `wb_way` steady until `wb_done`. That edge clears the fixed way's dirty bit, and `cp_req` follows in the next cycle.
- R8: `cp_req` is held with `cp_src` (the old way) and `cp_dst` (the fixed way) steady until `cp_done`. That edge marks the fixed way valid, priority 1, reference 1, with the old way's dirty bit, and leaves the old way invalid, clean, unreferenced and low priority.
- R9: From the accepting edge of a move until its `cp_done` edge, `req_ready` is 0 and any `req_valid` is ignored.
- R10: When the fixed way is clean or invalid, a move skips the writeback: `cp_req` rises in the cycle right after acceptance and `wb_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_addr | input | ADDR_W | Block address |
| req_cur_lead | input | 1 | Block is leading now |
| req_last_lead | input | 1 | Block was recorded as leading |
| req_way | input | WAY_W | Way the block currently occupies |
| req_write | input | 1 | Access writes the line |
| wb_req | output | 1 | Write back the fixed way's occupant |
| wb_way | output | WAY_W | Way to write back |
| wb_done | input | 1 | Writeback finished |
| cp_req | output | 1 | Copy line between ways |
| cp_src | output | WAY_W | Way copied from |
| cp_dst | output | WAY_W | Way copied to |
| cp_done | input | 1 | Copy finished |
| way_valid | output | WAYS | Valid bit per way |
| way_dirty | output | WAYS | Dirty bit per way |
| way_prio | output | WAYS | Priority (class) bit per way |
| way_ref | output | WAYS | Reference bit per way |

## Verification
Status bits change at the clock edge that takes the request, so the bench drives at the falling edge and reads all bits at the next falling edge, one cycle later. A move asserts `wb_req` or, with a clean fixed way, `cp_req` one cycle after acceptance. Each done pulse is driven for one cycle, and the bench samples the next phase or the final bits one cycle after that pulse. While a phase waits, the bench holds off several cycles and checks that the request stays up with steady way numbers and that a request offered meanwhile left no mark on the status bits.

// File: rtl/hyb_way_pkg.sv
package hyb_way_pkg;

    typedef enum logic [2:0] {
        ACT_TOUCH,
        ACT_DEMOTE,
        ACT_PROMOTE,
        ACT_COOL,
        ACT_MIGRATE
    } act_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_WB,
        SEQ_COPY
    } seq_e;

endpackage

// File: rtl/hyb_way_decide.sv
module hyb_way_decide
    import hyb_way_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WAYS   = 16,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              cur_lead,
    input  logic              last_lead,
    input  logic [WAY_W-1:0]  way,
    input  logic [WAYS-1:0]   valid_v,
    input  logic [WAYS-1:0]   dirty_v,
    input  logic [WAYS-1:0]   prio_v,
    input  logic [WAYS-1:0]   ref_v,
    output act_e              act,
    output logic [WAY_W-1:0]  fixed,
    output logic              need_wb
);
    // Fold two way-sized slices of the block index.
    assign fixed   = addr[WAY_W-1:0] ^ addr[2*WAY_W-1:WAY_W];
    assign need_wb = valid_v[fixed] & dirty_v[fixed];

    always_comb begin
        if (cur_lead == last_lead)
            act = ACT_TOUCH;
        else if (!cur_lead)
            act = ACT_DEMOTE;
        else if (way == fixed)
            act = ACT_PROMOTE;
        else if (valid_v[fixed] && prio_v[fixed] && ref_v[fixed])
            act = ACT_COOL;
        else
            act = ACT_MIGRATE;
    end
endmodule

// File: rtl/hyb_way_seq.sv
module hyb_way_seq
    import hyb_way_pkg::*;
#(
    parameter int WAYS   = 16,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  act_e             act,
    input  logic [WAY_W-1:0] way,
    input  logic [WAY_W-1:0] fixed,
    input  logic             need_wb,
    input  logic             wb_done,
    input  logic             cp_done,
    output logic             ready,
    output logic             wb_req,
    output logic             cp_req,
    output logic [WAY_W-1:0] src,
    output logic [WAY_W-1:0] dst,
    output logic             wb_clear,
    output logic             cp_commit
);
    seq_e st;

    assign ready     = (st == SEQ_IDLE);
    assign wb_req    = (st == SEQ_WB);
    assign cp_req    = (st == SEQ_COPY);
    assign wb_clear  = wb_req & wb_done;
    assign cp_commit = cp_req & cp_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SEQ_IDLE;
            src <= '0;
            dst <= '0;
        end else begin
            case (st)
                SEQ_IDLE: if (go && act == ACT_MIGRATE) begin
                    src <= way;
                    dst <= fixed;
                    st  <= need_wb ? SEQ_WB : SEQ_COPY;
                end
                SEQ_WB:   if (wb_done) st <= SEQ_COPY;
                SEQ_COPY: if (cp_done) st <= SEQ_IDLE;
                default:  st <= SEQ_IDLE;
            endcase
        end
    end

    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
        !(wb_req && cp_req)); // R7
    AST_WB_THEN_COPY: assert property (@(posedge clk) disable iff (rst)
        wb_req && wb_done |=> cp_req && $stable(dst) && $stable(src)); // R7
    AST_COPY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        cp_req && !cp_done |=> cp_req && $stable(src) && $stable(dst)); // R8
endmodule

// File: rtl/hyb_way_state.sv
module hyb_way_state
    import hyb_way_pkg::*;
#(
    parameter int WAYS   = 16,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch,
    input  act_e             act,
    input  logic [WAY_W-1:0] way,
    input  logic [WAY_W-1:0] fixed,
    input  logic             write,
    input  logic             wb_clear,
    input  logic             cp_commit,
    input  logic [WAY_W-1:0] src,
    input  logic [WAY_W-1:0] dst,
    output logic [WAYS-1:0]  valid_v,
    output logic [WAYS-1:0]  dirty_v,
    output logic [WAYS-1:0]  prio_v,
    output logic [WAYS-1:0]  ref_v
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_v <= '0;
            dirty_v <= '0;
            prio_v  <= '0;
            ref_v   <= '0;
        end else begin
            if (touch) begin
                valid_v[way] <= 1'b1;
                ref_v[way]   <= 1'b1;
                if (write) dirty_v[way] <= 1'b1;
                case (act)
                    ACT_DEMOTE:  prio_v[way]  <= 1'b0;
                    ACT_PROMOTE: prio_v[way]  <= 1'b1;
                    ACT_COOL:    ref_v[fixed] <= 1'b0;
                    default: ;
                endcase
            end
            if (wb_clear) dirty_v[dst] <= 1'b0;
            if (cp_commit) begin
                valid_v[dst] <= 1'b1;
                prio_v[dst]  <= 1'b1;
                ref_v[dst]   <= 1'b1;
                dirty_v[dst] <= dirty_v[src];
                valid_v[src] <= 1'b0;
                prio_v[src]  <= 1'b0;
                ref_v[src]   <= 1'b0;
                dirty_v[src] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hyb_way_ctrl.sv
module hyb_way_ctrl
    import hyb_way_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WAYS   = 16,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_cur_lead,
    input  logic              req_last_lead,
    input  logic [WAY_W-1:0]  req_way,
    input  logic              req_write,
    output logic              wb_req,
    output logic [WAY_W-1:0]  wb_way,
    input  logic              wb_done,
    output logic              cp_req,
    output logic [WAY_W-1:0]  cp_src,
    output logic [WAY_W-1:0]  cp_dst,
    input  logic              cp_done,
    output logic [WAYS-1:0]   way_valid,
    output logic [WAYS-1:0]   way_dirty,
    output logic [WAYS-1:0]   way_prio,
    output logic [WAYS-1:0]   way_ref
);
    act_e             act;
    logic [WAY_W-1:0] fixed;
    logic             need_wb;
    logic             go;
    logic             wb_clear;
    logic             cp_commit;

    assign go     = req_valid & req_ready;
    assign wb_way = cp_dst;

    hyb_way_decide #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_decide (
        .addr(req_addr), .cur_lead(req_cur_lead), .last_lead(req_last_lead),
        .way(req_way), .valid_v(way_valid), .dirty_v(way_dirty),
        .prio_v(way_prio), .ref_v(way_ref),
        .act(act), .fixed(fixed), .need_wb(need_wb)
    );

    hyb_way_seq #(.WAYS(WAYS)) u_seq (
        .clk(clk), .rst(rst), .go(go), .act(act), .way(req_way),
        .fixed(fixed), .need_wb(need_wb), .wb_done(wb_done), .cp_done(cp_done),
        .ready(req_ready), .wb_req(wb_req), .cp_req(cp_req),
        .src(cp_src), .dst(cp_dst), .wb_clear(wb_clear), .cp_commit(cp_commit)
    );

    hyb_way_state #(.WAYS(WAYS)) u_state (
        .clk(clk), .rst(rst), .touch(go), .act(act), .way(req_way),
        .fixed(fixed), .write(req_write), .wb_clear(wb_clear),
        .cp_commit(cp_commit), .src(cp_src), .dst(cp_dst),
        .valid_v(way_valid), .dirty_v(way_dirty), .prio_v(way_prio), .ref_v(way_ref)
    );

    AST_TOUCH_MARKS: assert property (@(posedge clk) disable iff (rst)
        go && (req_cur_lead == req_last_lead)
        |=> way_valid[$past(req_way)] && way_ref[$past(req_way)] && req_ready); // R3
    AST_DEMOTE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        go && req_last_lead && !req_cur_lead
        |=> !way_prio[$past(req_way)] && way_valid[$past(req_way)] && req_ready); // R4
    AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (rst)
        $rose(wb_req) |-> way_dirty[wb_way] && way_valid[wb_way]); // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (wb_req || cp_req) |-> !req_ready); // R9
    AST_MOVE_LANDS: assert property (@(posedge clk) disable iff (rst)
        cp_req && cp_done |=> way_valid[$past(cp_dst)] && way_prio[$past(cp_dst)]
                              && !way_valid[$past(cp_src)]); // R8
endmodule

// File: tb/hyb_way_ctrl_test.sv
`timescale 1ns/1ps
module hyb_way_ctrl_test;
    localparam int ADDR_W = 16;
    localparam int WAYS   = 16;
    localparam int WAY_W  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_cur_lead = 1'b0, req_last_lead = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [WAY_W-1:0]  req_way = '0;
    logic wb_done = 1'b0, cp_done = 1'b0;
    logic req_ready, wb_req, cp_req;
    logic [WAY_W-1:0] wb_way, cp_src, cp_dst;
    logic [WAYS-1:0] way_valid, way_dirty, way_prio, way_ref;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hyb_way_ctrl #(.ADDR_W(ADDR_W), .WAYS(WAYS)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_cur_lead(req_cur_lead), .req_last_lead(req_last_lead),
        .req_way(req_way), .req_write(req_write), .wb_req(wb_req), .wb_way(wb_way),
        .wb_done(wb_done), .cp_req(cp_req), .cp_src(cp_src), .cp_dst(cp_dst),
        .cp_done(cp_done), .way_valid(way_valid), .way_dirty(way_dirty),
        .way_prio(way_prio), .way_ref(way_ref)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Offer one request for one cycle; results are read one cycle later.
    task automatic issue(input logic [15:0] a, input logic [3:0] w,
                         input logic cur, input logic last, input logic wr);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_way = w;
        req_cur_lead = cur; req_last_lead = last; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic pulse_wb();
        wb_done = 1'b1;
        @(negedge clk);
        wb_done = 1'b0;
    endtask

    task automatic pulse_cp();
        cp_done = 1'b1;
        @(negedge clk);
        cp_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R2 ready", req_ready, 1);
        chk("R2 wb_req", wb_req, 0);
        chk("R2 cp_req", cp_req, 0);
        chk("R2 valid", way_valid, 0);
        chk("R2 dirty|prio|ref", way_dirty | way_prio | way_ref, 0);
    endtask

    task automatic t_touch();
        issue(16'h0021, 4'd3, 1'b0, 1'b0, 1'b1);
        chk("R3 valid3", way_valid[3], 1);
        chk("R3 ref3", way_ref[3], 1);
        chk("R3 dirty3", way_dirty[3], 1);
        chk("R3 prio3", way_prio[3], 0);
        chk("R3 ready", req_ready, 1);
        chk("R3 no move", {wb_req, cp_req}, 0);
    endtask

    task automatic t_promote_inplace();
        // 0x21: 1 ^ 2 = 3, equals the resident way
        issue(16'h0021, 4'd3, 1'b1, 1'b0, 1'b0);
        chk("R5 prio3", way_prio[3], 1);
        chk("R5 no move", {wb_req, cp_req, req_ready}, 3'b001);
    endtask

    task automatic t_demote();
        issue(16'h0021, 4'd3, 1'b0, 1'b1, 1'b0);
        chk("R4 prio3", way_prio[3], 0);
        chk("R4 valid3", way_valid[3], 1);
        chk("R4 no move", {wb_req, cp_req, req_ready}, 3'b001);
    endtask

    task automatic t_cool();
        issue(16'h0005, 4'd5, 1'b0, 1'b0, 1'b1);   // way 5 valid, dirty
        issue(16'h0005, 4'd5, 1'b1, 1'b0, 1'b0);   // way 5 leading, ref 1
        issue(16'h0027, 4'd7, 1'b0, 1'b0, 1'b0);   // way 7 valid, following
        // 0x27: 7 ^ 2 = 5, which holds a hot leading line
        issue(16'h0027, 4'd7, 1'b1, 1'b0, 1'b0);
        chk("R6 ref5 cleared", way_ref[5], 0);
        chk("R6 prio5 kept", way_prio[5], 1);
        chk("R6 way7 stays", {way_valid[7], way_prio[7]}, 2'b10);
        chk("R6 no move", {wb_req, cp_req, req_ready}, 3'b001);
    endtask

    task automatic t_migrate_wb();
        // way 5 now leading, ref 0, dirty: not hot, so the line moves
        issue(16'h0027, 4'd7, 1'b1, 1'b0, 1'b1);
        chk("R7 wb_req up", wb_req, 1);
        chk("R1 wb_way", wb_way, 5);
        chk("R9 ready low", req_ready, 0);
        // a request offered while busy must leave no mark
        issue(16'h0009, 4'd9, 1'b0, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        chk("R7 wb held", {wb_req, cp_req, wb_way}, {2'b10, 4'd5});
        chk("R9 ignored", {way_valid[9], way_dirty[9]}, 0);
        pulse_wb();
        chk("R7 copy next", {wb_req, cp_req}, 2'b01);
        chk("R7 dirty5 cleared", way_dirty[5], 0);
        chk("R1 cp_dst", cp_dst, 5);
        chk("R8 cp_src", cp_src, 7);
        repeat (3) @(negedge clk);
        chk("R8 copy held", {cp_req, cp_src, cp_dst}, {1'b1, 4'd7, 4'd5});
        pulse_cp();
        chk("R8 ready", {req_ready, cp_req}, 2'b10);
        chk("R8 dst bits", {way_valid[5], way_prio[5], way_ref[5], way_dirty[5]}, 4'b1111);
        chk("R8 src freed", {way_valid[7], way_prio[7], way_ref[7], way_dirty[7]}, 0);
        chk("R9 still ignored", way_valid[9], 0);
    endtask

    task automatic t_migrate_clean();
        // 0x0A: A ^ 0 = A, way 10 empty
        issue(16'h000A, 4'd2, 1'b0, 1'b0, 1'b0);
        issue(16'h000A, 4'd2, 1'b1, 1'b0, 1'b0);
        chk("R10 no writeback", {wb_req, cp_req}, 2'b01);
        chk("R1 dst 10", cp_dst, 10);
        chk("R10 src", cp_src, 2);
        pulse_cp();
        chk("R8 clean land", {way_valid[10], way_prio[10], way_dirty[10]}, 3'b110);
        chk("R8 clean free", way_valid[2], 0);
        // 0x5A: A ^ 5 = F, way 15 empty and clean
        issue(16'h005A, 4'd1, 1'b1, 1'b0, 1'b0);
        chk("R1 dst 15", {cp_req, cp_dst}, {1'b1, 4'd15});
        pulse_cp();
        chk("R8 way15", {way_valid[15], way_prio[15], way_valid[1]}, 3'b110);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_touch();
        t_promote_inplace();
        t_demote();
        t_cool();
        t_migrate_wb();
        t_migrate_clean();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule